// File: doc/BRIEF.md
# DMA Multi-Block Chaining Sequencer

This block steers one DMA channel through a transfer made of several blocks. Software loads a source address, a destination address, a control word, a next-descriptor pointer and a source-reload enable, then writes the channel-enable. The sequencer starts a block on an external data mover and waits for that mover to report the block finished. It then either ends the transfer or prepares the next block. To prepare it, the source address may be restored to its starting value, and a three-word descriptor may be fetched from memory to supply a new destination, control word and pointer.

After each block the sequencer can raise a block-complete flag. When that flag's interrupt is unmasked and the control word enables interrupts, the channel holds until software clears the flag. Software ends the chain by turning source reload off once the last descriptor has a zero pointer. When the final block finishes, the transfer-complete flag is set and the channel-enable drops, so software can poll the enable instead of taking an interrupt.

Top module: `dma_chain_seq`

## Requirements
- R1: At each block end with reload on, `src_o` returns to the source address latched at channel start. With reload off, it takes `blk_src_end_i`.
- R2: A descriptor fetch reads three words at `llp_o`, `llp_o`+4 and `llp_o`+8, one request outstanding at a time. It accepts one word per `mem_rvalid_i`. The words are, in order, destination, control, next pointer.
- R3: A descriptor fetch updates `dst_o`, `ctl_o` and `llp_o` only. `src_o` keeps its value.
- R4: When control bit 0 (interrupt enable) is 1 and `blk_unmask_i` is 1, a block end sets `blk_flag_o`. No block start or memory request is issued until that flag reads 0.
- R5: When control bit 0 is 0 or `blk_unmask_i` is 0, the next block starts with no clear needed. With control bit 0 at 0, `blk_flag_o` stays 0.
- R6: A block end with reload off and `llp_o` equal to zero sets `xfer_flag_o` and clears `ch_en_o`. After that, no block start and no memory request is issued.
- R7: `ch_en_o` reads 1 from the cycle after a start until the final block end, so polling it detects completion.
- R8: A 1 on `blk_clr_i` or `xfer_clr_i` clears that flag. A set in the same cycle wins. `irq_o` is (`blk_flag_o` AND `blk_unmask_i`) OR `xfer_flag_o`.
- R9: `start_i` while the channel is disabled latches all initial values, and `blk_start_o` pulses in the next cycle. `start_i` while enabled has no effect.
- R10: With reload on and `llp_o` zero, the block repeats from the restored source with no memory read. A nonzero `llp_o` at block end triggers a fetch.
- R11: A 1 on `reload_clr_i` turns `reload_o` off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Write of channel-enable |
| init_src_i | input | 32 | Initial source address |
| init_dst_i | input | 32 | Initial destination address |
| init_ctl_i | input | 32 | Initial control word, bit 0 is interrupt enable |
| init_llp_i | input | 32 | Initial next-descriptor pointer |
| init_reload_i | input | 1 | Initial source-reload enable |
| reload_clr_i | input | 1 | Turns source reload off |
| blk_unmask_i | input | 1 | Block-complete interrupt unmask |
| blk_clr_i | input | 1 | Block-complete flag clear |
| xfer_clr_i | input | 1 | Transfer-complete flag clear |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| blk_start_o | output | 1 | One-cycle block start to the mover |
| blk_done_i | input | 1 | Block finished |
| blk_src_end_i | input | 32 | Source address reached by the mover |
| src_o | output | 32 | Current source address |
| dst_o | output | 32 | Current destination address |
| ctl_o | output | 32 | Current control word |
| llp_o | output | 32 | Current next-descriptor pointer |
| reload_o | output | 1 | Source-reload enable |
| ch_en_o | output | 1 | Channel enable |
| blk_flag_o | output | 1 | Block-complete flag |
| xfer_flag_o | output | 1 | Transfer-complete flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong sequencing state shows up within a few cycles of a block end. A missing stall produces a `blk_start_o` while the flag is still set. A skipped or misdirected fetch shows as wrong or missing addresses on the read port, or as a destination that did not change. A bad completion decision either leaves `ch_en_o` high with no further start, or drops it while the pointer is still nonzero. A corrupted source register is visible on `src_o` from the edge after the block end.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BUSY,
    ST_WAIT,
    ST_FETCH
  } seq_state_e;

  localparam int DESC_WORDS = 3;
  // word order within a descriptor
  localparam int IDX_DST = 0;
  localparam int IDX_CTL = 1;
  localparam int IDX_NXT = 2;
endpackage

// File: rtl/dcs_fetch.sv
module dcs_fetch #(
  parameter int W       = 32,
  parameter int N_WORDS = 3,
  localparam int IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [W-1:0]  base_i,
  input  logic          rvalid_i,
  output logic          req_o,
  output logic [W-1:0]  addr_o,
  output logic          word_vld_o,
  output logic [IW-1:0] word_idx_o,
  output logic          done_o
);
  logic          active_q, pend_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  base_q;

  assign req_o      = active_q & ~pend_q;
  assign addr_o     = base_q + W'({idx_q, 2'b00});
  assign word_vld_o = pend_q & rvalid_i;
  assign word_idx_o = idx_q;
  assign done_o     = word_vld_o & (idx_q == IW'(N_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      pend_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= base_i;
    end else if (req_o) begin
      pend_q <= 1'b1;
    end else if (word_vld_o) begin
      pend_q <= 1'b0;
      if (done_o) active_q <= 1'b0;
      else        idx_q    <= idx_q + 1'b1;
    end
  end

  // R2: after a non-final word the next sequential word is requested
  a_r2_next_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && !done_o && !go_i) |=> (req_o && addr_o == $past(addr_o) + W'(4)));
  a_r2_no_req_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !rvalid_i) |=> !req_o);
endmodule

// File: rtl/dcs_irq.sv
module dcs_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_blk_i,
  input  logic set_xfer_i,
  input  logic clr_blk_i,
  input  logic clr_xfer_i,
  input  logic unmask_i,
  output logic blk_flag_o,
  output logic xfer_flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_flag_o  <= 1'b0;
      xfer_flag_o <= 1'b0;
    end else begin
      if (set_blk_i)       blk_flag_o  <= 1'b1;
      else if (clr_blk_i)  blk_flag_o  <= 1'b0;
      if (set_xfer_i)      xfer_flag_o <= 1'b1;
      else if (clr_xfer_i) xfer_flag_o <= 1'b0;
    end
  end

  assign irq_o = (blk_flag_o & unmask_i) | xfer_flag_o;

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_blk_i && clr_blk_i) |=> blk_flag_o);
  a_r8_clear_blk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_blk_i && !set_blk_i) |=> !blk_flag_o);
  a_r8_clear_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_xfer_i && !set_xfer_i) |=> !xfer_flag_o);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int W          = 32,
  parameter int INT_EN_BIT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] init_src_i,
  input  logic [W-1:0] init_dst_i,
  input  logic [W-1:0] init_ctl_i,
  input  logic [W-1:0] init_llp_i,
  input  logic         init_reload_i,
  input  logic         reload_clr_i,
  input  logic         blk_unmask_i,
  input  logic         blk_clr_i,
  input  logic         xfer_clr_i,
  output logic         mem_req_o,
  output logic [W-1:0] mem_addr_o,
  input  logic         mem_rvalid_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         blk_start_o,
  input  logic         blk_done_i,
  input  logic [W-1:0] blk_src_end_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] dst_o,
  output logic [W-1:0] ctl_o,
  output logic [W-1:0] llp_o,
  output logic         reload_o,
  output logic         ch_en_o,
  output logic         blk_flag_o,
  output logic         xfer_flag_o,
  output logic         irq_o
);
  localparam int IW = $clog2(DESC_WORDS);

  seq_state_e    state_q, state_d;
  logic [W-1:0]  sar_q, sar_init_q, dar_q, ctl_q, llp_q;
  logic          reload_q, ch_en_q;
  logic          blk_end, last_blk, stall, has_next, launch;
  logic          fetch_go, word_vld, fetch_done;
  logic [IW-1:0] word_idx;

  assign launch   = (state_q == ST_IDLE) & start_i;
  assign blk_end  = (state_q == ST_BUSY) & blk_done_i;
  assign has_next = (llp_q != '0);
  assign last_blk = ~reload_q & ~has_next;
  assign stall    = ctl_q[INT_EN_BIT] & blk_unmask_i;

  always_comb begin
    state_d  = state_q;
    fetch_go = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_START;
      ST_START: state_d = ST_BUSY;
      ST_BUSY: if (blk_done_i) begin
        if (last_blk)      state_d = ST_IDLE;
        else if (stall)    state_d = ST_WAIT;
        else if (has_next) begin state_d = ST_FETCH; fetch_go = 1'b1; end
        else               state_d = ST_START;
      end
      ST_WAIT: if (!blk_flag_o) begin
        if (has_next) begin state_d = ST_FETCH; fetch_go = 1'b1; end
        else          state_d = ST_START;
      end
      ST_FETCH: if (fetch_done) state_d = ST_START;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sar_q      <= '0;
      sar_init_q <= '0;
      dar_q      <= '0;
      ctl_q      <= '0;
      llp_q      <= '0;
      reload_q   <= 1'b0;
      ch_en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        sar_q      <= init_src_i;
        sar_init_q <= init_src_i;
        dar_q      <= init_dst_i;
        ctl_q      <= init_ctl_i;
        llp_q      <= init_llp_i;
        ch_en_q    <= 1'b1;
      end
      if (launch)            reload_q <= init_reload_i;
      else if (reload_clr_i) reload_q <= 1'b0;
      if (blk_end) begin
        sar_q <= reload_q ? sar_init_q : blk_src_end_i;
        if (last_blk) ch_en_q <= 1'b0;
      end
      if (word_vld) begin
        if (word_idx == IW'(IDX_DST)) dar_q <= mem_rdata_i;
        if (word_idx == IW'(IDX_CTL)) ctl_q <= mem_rdata_i;
        if (word_idx == IW'(IDX_NXT)) llp_q <= mem_rdata_i;
      end
    end
  end

  dcs_fetch #(.W(W), .N_WORDS(DESC_WORDS)) i_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (fetch_go),
    .base_i     (llp_q),
    .rvalid_i   (mem_rvalid_i),
    .req_o      (mem_req_o),
    .addr_o     (mem_addr_o),
    .word_vld_o (word_vld),
    .word_idx_o (word_idx),
    .done_o     (fetch_done)
  );

  dcs_irq i_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_blk_i   (blk_end & ctl_q[INT_EN_BIT]),
    .set_xfer_i  (blk_end & last_blk),
    .clr_blk_i   (blk_clr_i),
    .clr_xfer_i  (xfer_clr_i),
    .unmask_i    (blk_unmask_i),
    .blk_flag_o  (blk_flag_o),
    .xfer_flag_o (xfer_flag_o),
    .irq_o       (irq_o)
  );

  assign blk_start_o = (state_q == ST_START);
  assign src_o       = sar_q;
  assign dst_o       = dar_q;
  assign ctl_o       = ctl_q;
  assign llp_o       = llp_q;
  assign reload_o    = reload_q;
  assign ch_en_o     = ch_en_q;

  a_r1_reload_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && blk_done_i && reload_q) |=> (sar_q == sar_init_q));
  a_r3_src_kept_in_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |=> $stable(sar_q));
  a_r4_hold_while_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && blk_flag_o) |-> (!blk_start_o && !mem_req_o));
  a_r6_end_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && blk_done_i && !reload_q && llp_q == '0) |=> (!ch_en_o && xfer_flag_o));
  a_r6_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_en_o |-> (!mem_req_o && !blk_start_o));
  a_r7_enabled_in_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_o |-> ch_en_o);
endmodule

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, reload_clr = 0, unmask = 0, blk_clr = 0, xfer_clr = 0;
  logic [31:0] i_src = 0, i_dst = 0, i_ctl = 0, i_llp = 0;
  logic        i_rel = 0;
  logic        mem_req, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        blk_start, blk_done = 0;
  logic [31:0] src_end = 0;
  logic [31:0] src, dst, ctl, llp;
  logic        reload, ch_en, blk_flag, xfer_flag, irq;

  int checks = 0, fails = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] addr_log [$];

  always #2 clk = ~clk;

  dma_chain_seq i_dma_chain_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .init_src_i(i_src), .init_dst_i(i_dst), .init_ctl_i(i_ctl), .init_llp_i(i_llp),
    .init_reload_i(i_rel), .reload_clr_i(reload_clr), .blk_unmask_i(unmask),
    .blk_clr_i(blk_clr), .xfer_clr_i(xfer_clr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .blk_start_o(blk_start), .blk_done_i(blk_done), .blk_src_end_i(src_end),
    .src_o(src), .dst_o(dst), .ctl_o(ctl), .llp_o(llp), .reload_o(reload),
    .ch_en_o(ch_en), .blk_flag_o(blk_flag), .xfer_flag_o(xfer_flag), .irq_o(irq)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= (mem_req && mem.exists(mem_addr)) ? mem[mem_addr] : 32'h0;
    if (mem_req) addr_log.push_back(mem_addr);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_start(input int lim, output bit found);
    found = 0;
    for (int i = 0; i < lim; i++) begin
      if (blk_start) begin found = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_block(logic [31:0] end_addr, bit with_clr);
    @(negedge clk);
    blk_done = 1; src_end = end_addr; blk_clr = with_clr;
    @(negedge clk);
    blk_done = 0; blk_clr = 0;
  endtask

  task automatic quiet_window(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (blk_start || mem_req) seen++;
      @(negedge clk);
    end
    check(req, seen, 0);
  endtask

  task automatic launch(logic [31:0] s, logic [31:0] d, logic [31:0] c, logic [31:0] p, logic r);
    @(negedge clk);
    i_src = s; i_dst = d; i_ctl = c; i_llp = p; i_rel = r; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1; @(negedge clk); sig = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit found;
    mem[32'h100] = 32'h3000; mem[32'h104] = 32'h0; mem[32'h108] = 32'h200;
    mem[32'h200] = 32'h4000; mem[32'h204] = 32'h0; mem[32'h208] = 32'h0;
    repeat (3) @(negedge clk);
    check("reset ch_en", ch_en, 0);
    check("reset flags", {blk_flag, xfer_flag, irq}, 0);
    check("reset outputs", {mem_req, blk_start}, 0);
    rst_n = 1;
    @(negedge clk);

    // ---- chain: reload + two descriptors, interrupts off ----
    launch(32'h1000, 32'h2000, 32'h0, 32'h100, 1);
    check("R9 start pulse", blk_start, 1);
    check("R9 src latched", src, 32'h1000);
    check("R9 dst latched", dst, 32'h2000);
    check("R7 enable set", ch_en, 1);
    @(negedge clk);
    i_src = 32'hdead; i_dst = 32'hbeef; start = 1;
    @(negedge clk); start = 0;
    check("R9 start ignored src", src, 32'h1000);
    check("R9 start ignored dst", dst, 32'h2000);
    finish_block(32'h1040, 0);
    check("R1 reload restores src", src, 32'h1000);
    wait_start(50, found);
    check("R5 next start without clear", found, 1);
    check("R2 read count", addr_log.size(), 3);
    if (addr_log.size() == 3) begin
      check("R2 addr0", addr_log[0], 32'h100);
      check("R2 addr1", addr_log[1], 32'h104);
      check("R2 addr2", addr_log[2], 32'h108);
    end
    check("R3 dst from descriptor", dst, 32'h3000);
    check("R3 ptr from descriptor", llp, 32'h200);
    check("R3 src untouched", src, 32'h1000);
    check("R5 flag stays low", blk_flag, 0);
    pulse(reload_clr);
    check("R11 reload off", reload, 0);
    finish_block(32'h1080, 0);
    check("R1 no reload takes end addr", src, 32'h1080);
    wait_start(50, found);
    check("R10 second fetch start", found, 1);
    check("R2 total reads", addr_log.size(), 6);
    if (addr_log.size() == 6) check("R2 second base", addr_log[3], 32'h200);
    check("R3 dst second", dst, 32'h4000);
    check("R7 still enabled", ch_en, 1);
    finish_block(32'h10c0, 0);
    check("R6 enable cleared", ch_en, 0);
    check("R6 xfer flag", xfer_flag, 1);
    check("R8 irq from xfer", irq, 1);
    quiet_window(10, "R6 no activity after end");
    pulse(xfer_clr);
    check("R8 xfer cleared", xfer_flag, 0);

    // ---- reload-only repeat with stall ----
    unmask = 1;
    launch(32'h5000, 32'h6000, 32'h1, 32'h0, 1);
    check("R9 second launch", blk_start, 1);
    finish_block(32'h5100, 1);
    check("R8 set wins over clear", blk_flag, 1);
    check("R8 irq unmasked", irq, 1);
    check("R1 repeat src", src, 32'h5000);
    quiet_window(8, "R4 hold while flagged");
    check("R10 no reads on repeat", addr_log.size(), 6);
    pulse(blk_clr);
    wait_start(10, found);
    check("R4 resumes after clear", found, 1);
    unmask = 0;
    finish_block(32'h5100, 0);
    check("R5 flag set when masked", blk_flag, 1);
    check("R8 irq masked", irq, 0);
    wait_start(10, found);
    check("R5 masked no stall", found, 1);
    pulse(blk_clr);
    pulse(reload_clr);
    finish_block(32'h5200, 0);
    check("R6 end after reload off", {ch_en, xfer_flag}, 2'b01);
    check("R1 final src", src, 32'h5200);
    quiet_window(6, "R6 quiet at end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule